// File: doc/BRIEF.md
# Discrete Sense SPI Register Interface

This block is the serial front end of a 32-channel discrete-input sensing device. An SPI master in mode 0 (clock idles low, data sampled on the rising SCLK edge, changed on the falling edge) sends a command byte whose top bit selects read or write and whose low seven bits select a register. The block holds a small set of configuration registers (a control byte, a per-bank sensing-mode byte and two 16-bit threshold words), presents their contents on parallel outputs, and returns the live sense vector taken from a parallel input.

All SPI pins are sampled with the system clock, which must run several times faster than SCLK. Multi-byte fields travel most significant byte first. The sense vector can be fetched either as four separate bank bytes or as one 32-bit word. Data for a read is captured at the clock edge that completes the command byte, so a multi-byte read returns one coherent snapshot.

Top module: `discreteSenseSpiRegs`

## Requirements
- R1: The first byte after chip select falls is a command: bit 7 = 1 selects a read, bit 7 = 0 selects a write, and bits 6:0 give the register address.
- R2: Address 0x02 is the control byte (bit 0 test enable on `ctrlTest`, bit 1 software reset on `ctrlSwReset`) and address 0x04 is the bank-mode byte (bit n on `bankMode[n]` selects the mode of channels 8n to 8n+7); both are written by one data byte and read back with unused bits as 0.
- R3: The ground-open threshold (0x3A) and supply-open threshold (0x3C) are written as command, high byte, low byte; the register changes only at the edge that completes the low byte, and a transaction that ends after the high byte leaves it unchanged. Reads return high byte first.
- R4: A read of 0x78 returns the 32 sense bits in four bytes, channel 31 first, taken from `senseIn` at the clock edge that completes the command byte; later changes of `senseIn` do not affect that transaction. The first data bit is on MISO before the first data SCLK rising edge and each next bit follows a falling edge.
- R5: Reads of 0x10, 0x12, 0x14 and 0x16 return one byte holding channels 0-7, 8-15, 16-23 and 24-31 respectively, the highest channel of the bank in bit 7.
- R6: From the edge that stores a control byte with bit 1 set until bit 1 is cleared, the bank-mode and both threshold registers read 0 and writes to them are ignored; after bit 1 is cleared they keep 0 until written again.
- R7: Reads of unmapped addresses return 0x00; writes to unmapped addresses and to the read-only sense addresses change no register.
- R8: MISO is 0 whenever chip select is high, during the command byte, and throughout a write transaction.
- R9: Raising chip select discards a partial byte; the next transaction starts with a fresh command byte.
- R10: Read bytes beyond a register's width return 0x00, and write bytes beyond a register's width are ignored.
- R11: After reset every register output is 0 and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rstN | input | 1 | Active-low asynchronous reset |
| spiCsN | input | 1 | Active-low chip select |
| spiSclk | input | 1 | Serial clock, idle low |
| spiMosi | input | 1 | Serial data from master |
| spiMiso | output | 1 | Serial data to master, 0 when not reading |
| senseIn | input | NUM_CH | Live discrete sense bits, bit n is channel n |
| ctrlTest | output | 1 | Test-mode enable from the control byte |
| ctrlSwReset | output | 1 | Software reset from the control byte |
| bankMode | output | NUM_CH/8 | Sensing mode per bank of 8 channels |
| threshGnd | output | 16 | Ground-open threshold word |
| threshSup | output | 16 | Supply-open threshold word |

## Verification
Two collisions matter here. A change of `senseIn` can land in the very clock in which the command byte for 0x78 completes, and the bench forces this by driving the new vector in the same cycle as the eighth command SCLK rising edge, then changes it again during the data bytes; only the value present at that edge may come back. A control write that sets the software reset can also coincide with forcing the other registers, and the bench judges that the bank-mode and threshold outputs drop to 0 in the same cycle the control output changes, and that a later threshold write in that state is ignored.

// File: rtl/spiRegPkg.sv
package spiRegPkg;

  localparam int ADDR_W  = 7;
  localparam int THR_W   = 16;
  localparam int WORD_W  = 32;

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 7'h02;
  localparam logic [ADDR_W-1:0] ADDR_BANKMODE = 7'h04;
  localparam logic [ADDR_W-1:0] ADDR_SENSE0   = 7'h10;
  localparam logic [ADDR_W-1:0] ADDR_THR_GND  = 7'h3A;
  localparam logic [ADDR_W-1:0] ADDR_THR_SUP  = 7'h3C;
  localparam logic [ADDR_W-1:0] ADDR_SENSEALL = 7'h78;

  // Bank bytes sit on even addresses starting at ADDR_SENSE0.
  function automatic logic [ADDR_W-1:0] senseBankAddr(input int bank);
    return ADDR_W'(int'(ADDR_SENSE0) + 2 * bank);
  endfunction

  // Strobes from the serial control to the register datapath.
  typedef struct packed {
    logic              cmdDone;
    logic              cmdRead;
    logic [ADDR_W-1:0] cmdAddr;
    logic              wrDone;
    logic [ADDR_W-1:0] wrAddr;
    logic [1:0]        wrIdx;
    logic [7:0]        wrByte;
    logic              shiftOut;
  } spiStrobe_t;

endpackage

// File: rtl/spiFrameCtrl.sv
module spiFrameCtrl
  import spiRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       mosi,
  output spiStrobe_t strb,
  output logic       rdActive
);

  logic              sclkPrev;
  logic [2:0]        bitCnt;
  logic [6:0]        shiftIn;
  logic              inData;
  logic              isRead;
  logic              pendShift;
  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        idxQ;

  logic       rise;
  logic       fall;
  logic       byteDone;
  logic [7:0] fullByte;

  assign rise     = sclk & ~sclkPrev & ~csN;
  assign fall     = ~sclk & sclkPrev & ~csN;
  assign byteDone = rise & (bitCnt == 3'd7);
  assign fullByte = {shiftIn, mosi};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      bitCnt    <= '0;
      shiftIn   <= '0;
      inData    <= 1'b0;
      isRead    <= 1'b0;
      pendShift <= 1'b0;
      addrQ     <= '0;
      idxQ      <= '0;
    end else begin
      sclkPrev <= sclk;
      if (csN) begin
        bitCnt    <= '0;
        inData    <= 1'b0;
        isRead    <= 1'b0;
        pendShift <= 1'b0;
        idxQ      <= '0;
      end else if (rise) begin
        bitCnt  <= bitCnt + 3'd1;
        shiftIn <= {shiftIn[5:0], mosi};
        if (inData) pendShift <= 1'b1;
        if (byteDone) begin
          if (!inData) begin
            inData <= 1'b1;
            isRead <= fullByte[7];
            addrQ  <= fullByte[ADDR_W-1:0];
          end else if (idxQ != 2'd3) begin
            idxQ <= idxQ + 2'd1;
          end
        end
      end else if (fall) begin
        pendShift <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.cmdDone  = byteDone & ~inData;
    strb.cmdRead  = fullByte[7];
    strb.cmdAddr  = fullByte[ADDR_W-1:0];
    strb.wrDone   = byteDone & inData & ~isRead;
    strb.wrAddr   = addrQ;
    strb.wrIdx    = idxQ;
    strb.wrByte   = fullByte;
    strb.shiftOut = fall & pendShift;
  end

  assign rdActive = inData & isRead & ~csN;

endmodule

// File: rtl/senseRegDatapath.sv
module senseRegDatapath
  import spiRegPkg::*;
#(
  parameter int NUM_CH   = 32,
  parameter int NUM_BANK = NUM_CH / 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  spiStrobe_t          strb,
  input  logic                rdActive,
  input  logic [NUM_CH-1:0]   senseIn,
  output logic                miso,
  output logic                ctrlTest,
  output logic                ctrlSwReset,
  output logic [NUM_BANK-1:0] bankMode,
  output logic [THR_W-1:0]    threshGnd,
  output logic [THR_W-1:0]    threshSup
);

  logic [7:0]        bankByte [NUM_BANK];
  logic [WORD_W-1:0] rdWord;
  logic [WORD_W-1:0] rdShift;
  logic [7:0]        thrHigh;
  logic              wrFirst;
  logic              wrSecond;
  logic              swResetNext;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    assign bankByte[b] = senseIn[8*b +: 8];
  end

  // Read value, left aligned so the first byte out is bits 31:24.
  always_comb begin
    case (strb.cmdAddr)
      ADDR_CTRL:     rdWord = {6'b0, ctrlSwReset, ctrlTest, 24'b0};
      ADDR_BANKMODE: rdWord = {8'(bankMode), 24'b0};
      ADDR_THR_GND:  rdWord = {threshGnd, 16'b0};
      ADDR_THR_SUP:  rdWord = {threshSup, 16'b0};
      ADDR_SENSEALL: rdWord = WORD_W'(senseIn);
      default:       rdWord = '0;
    endcase
    for (int b = 0; b < NUM_BANK; b++) begin
      if (strb.cmdAddr == senseBankAddr(b)) rdWord = {bankByte[b], 24'b0};
    end
  end

  assign wrFirst  = strb.wrDone & (strb.wrIdx == 2'd0);
  assign wrSecond = strb.wrDone & (strb.wrIdx == 2'd1);

  // A control write that sets the reset bit forces the others at the same edge.
  assign swResetNext = (wrFirst && strb.wrAddr == ADDR_CTRL) ? strb.wrByte[1] : ctrlSwReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlTest    <= 1'b0;
      ctrlSwReset <= 1'b0;
      bankMode    <= '0;
      threshGnd   <= '0;
      threshSup   <= '0;
      thrHigh     <= '0;
    end else begin
      if (wrFirst && strb.wrAddr == ADDR_CTRL) begin
        ctrlTest    <= strb.wrByte[0];
        ctrlSwReset <= strb.wrByte[1];
      end
      if (wrFirst && (strb.wrAddr == ADDR_THR_GND || strb.wrAddr == ADDR_THR_SUP))
        thrHigh <= strb.wrByte;
      if (swResetNext) begin
        bankMode  <= '0;
        threshGnd <= '0;
        threshSup <= '0;
      end else begin
        if (wrFirst && strb.wrAddr == ADDR_BANKMODE)
          bankMode <= strb.wrByte[NUM_BANK-1:0];
        if (wrSecond && strb.wrAddr == ADDR_THR_GND)
          threshGnd <= {thrHigh, strb.wrByte};
        if (wrSecond && strb.wrAddr == ADDR_THR_SUP)
          threshSup <= {thrHigh, strb.wrByte};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdShift <= '0;
    end else if (strb.cmdDone && strb.cmdRead) begin
      rdShift <= rdWord;
    end else if (strb.shiftOut) begin
      rdShift <= {rdShift[WORD_W-2:0], 1'b0};
    end
  end

  assign miso = rdActive & rdShift[WORD_W-1];

endmodule

// File: rtl/discreteSenseSpiRegs.sv
module discreteSenseSpiRegs
  import spiRegPkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int NUM_BANK = NUM_CH / 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                spiCsN,
  input  logic                spiSclk,
  input  logic                spiMosi,
  output logic                spiMiso,
  input  logic [NUM_CH-1:0]   senseIn,
  output logic                ctrlTest,
  output logic                ctrlSwReset,
  output logic [NUM_BANK-1:0] bankMode,
  output logic [THR_W-1:0]    threshGnd,
  output logic [THR_W-1:0]    threshSup
);

  spiStrobe_t strb;
  logic       rdActive;

  spiFrameCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csN      (spiCsN),
    .sclk     (spiSclk),
    .mosi     (spiMosi),
    .strb     (strb),
    .rdActive (rdActive)
  );

  senseRegDatapath #(
    .NUM_CH   (NUM_CH),
    .NUM_BANK (NUM_BANK)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rdActive    (rdActive),
    .senseIn     (senseIn),
    .miso        (spiMiso),
    .ctrlTest    (ctrlTest),
    .ctrlSwReset (ctrlSwReset),
    .bankMode    (bankMode),
    .threshGnd   (threshGnd),
    .threshSup   (threshSup)
  );

endmodule

// File: rtl/discreteSenseSpiRegsChk.sv
module discreteSenseSpiRegsChk #(
  parameter int NUM_BANK = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                spiCsN,
  input logic                spiMiso,
  input logic                ctrlSwReset,
  input logic [NUM_BANK-1:0] bankMode,
  input logic [15:0]         threshGnd,
  input logic [15:0]         threshSup
);

  // R8
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiMiso);

  // R6
  swreset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlSwReset |-> (bankMode == '0 && threshGnd == '0 && threshSup == '0));

  // R3
  thresh_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |=> ($stable(threshGnd) && $stable(threshSup)));

  // R2
  bank_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |=> $stable(bankMode));

endmodule

bind discreteSenseSpiRegs discreteSenseSpiRegsChk #(.NUM_BANK(NUM_BANK)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .spiCsN      (spiCsN),
  .spiMiso     (spiMiso),
  .ctrlSwReset (ctrlSwReset),
  .bankMode    (bankMode),
  .threshGnd   (threshGnd),
  .threshSup   (threshSup)
);

// File: tb/discreteSenseSpiRegs_bench.sv
module discreteSenseSpiRegs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int NUM_CH     = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spiCsN = 1'b1;
  logic        spiSclk = 1'b0;
  logic        spiMosi = 1'b0;
  logic        spiMiso;
  logic [31:0] senseIn = '0;
  logic        ctrlTest;
  logic        ctrlSwReset;
  logic [3:0]  bankMode;
  logic [15:0] threshGnd;
  logic [15:0] threshSup;

  discreteSenseSpiRegs u_discreteSenseSpiRegs (
    .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .senseIn(senseIn), .ctrlTest(ctrlTest), .ctrlSwReset(ctrlSwReset),
    .bankMode(bankMode), .threshGnd(threshGnd), .threshSup(threshSup)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string curReq = "R11";

  // Behavioural model of the register file.
  logic        mTest = 0, mSwr = 0;
  logic [3:0]  mBank = '0;
  logic [15:0] mGnd = '0, mSup = '0;
  logic [7:0]  mHold = '0;
  int          bIdx = 0;
  logic        bRead = 0;
  logic [6:0]  bAddr = '0;
  logic [31:0] snap = '0;
  logic        senseAtCmd = 0;
  logic [31:0] senseCmdVal = '0;
  logic        senseMid = 0;
  logic [31:0] senseMidVal = '0;

  logic [7:0] tx [5];
  logic [7:0] rx [5];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] modelWord(input logic [6:0] a);
    logic [31:0] w;
    w = '0;
    if (a == 7'h02) w = {6'b0, mSwr, mTest, 24'b0};
    else if (a == 7'h04) w = {4'b0, mBank, 24'b0};
    else if (a == 7'h3A) w = {mGnd, 16'b0};
    else if (a == 7'h3C) w = {mSup, 16'b0};
    else if (a == 7'h78) w = senseIn;
    else if (a == 7'h10) w = {senseIn[7:0], 24'b0};
    else if (a == 7'h12) w = {senseIn[15:8], 24'b0};
    else if (a == 7'h14) w = {senseIn[23:16], 24'b0};
    else if (a == 7'h16) w = {senseIn[31:24], 24'b0};
    return w;
  endfunction

  task automatic applyByte(input logic [7:0] b);
    if (bIdx == 0) begin
      if (senseAtCmd) begin senseIn = senseCmdVal; senseAtCmd = 0; end
      bRead = b[7];
      bAddr = b[6:0];
      if (bRead) snap = modelWord(bAddr);
    end else begin
      if (bIdx == 1 && senseMid) begin senseIn = senseMidVal; senseMid = 0; end
      if (!bRead) begin
        if (bIdx == 1) begin
          if (bAddr == 7'h02) begin
            mTest = b[0]; mSwr = b[1];
            if (b[1]) begin mBank = '0; mGnd = '0; mSup = '0; end
          end
          if (bAddr == 7'h04 && !mSwr) mBank = b[3:0];
          if (bAddr == 7'h3A || bAddr == 7'h3C) mHold = b;
        end else if (bIdx == 2 && !mSwr) begin
          if (bAddr == 7'h3A) mGnd = {mHold, b};
          if (bAddr == 7'h3C) mSup = {mHold, b};
        end
      end
    end
    bIdx++;
  endtask

  task automatic doByte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      spiMosi = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = spiMiso;
      spiSclk = 1'b1;
      if (i == 0) applyByte(b);
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
  endtask

  task automatic xfer(input int n);
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      logic [7:0] r;
      doByte(tx[k], r);
      rx[k] = r;
    end
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    bIdx = 0;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic partialBits(input int nb, input logic [7:0] b);
    @(negedge clk);
    spiCsN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 7; i > 7 - nb; i--) begin
      spiMosi = b[i];
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spiSclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spiCsN = 1'b1;
    bIdx = 0;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d);
    tx[0] = {1'b0, a}; tx[1] = d;
    xfer(2);
  endtask

  task automatic wr2(input logic [6:0] a, input logic [15:0] d);
    tx[0] = {1'b0, a}; tx[1] = d[15:8]; tx[2] = d[7:0];
    xfer(3);
  endtask

  task automatic rdChk(input logic [6:0] a, input int nData, input string req);
    tx[0] = {1'b1, a};
    for (int k = 1; k < 5; k++) tx[k] = 8'h00;
    xfer(nData + 1);
    for (int k = 1; k <= nData; k++) begin
      logic [7:0] e;
      e = (k <= 4) ? snap[31 - 8*(k-1) -: 8] : 8'h00;
      chk(rx[k] === e, req, 32'(rx[k]), 32'(e));
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rstN && !finished) begin
      chk(ctrlTest === mTest, curReq, 32'(ctrlTest), 32'(mTest));
      chk(ctrlSwReset === mSwr, curReq, 32'(ctrlSwReset), 32'(mSwr));
      chk(bankMode === mBank, curReq, 32'(bankMode), 32'(mBank));
      chk(threshGnd === mGnd, curReq, 32'(threshGnd), 32'(mGnd));
      chk(threshSup === mSup, curReq, 32'(threshSup), 32'(mSup));
      // R8: MISO quiet outside the read data phase
      if (spiCsN || bIdx == 0 || !bRead)
        chk(spiMiso === 1'b0, "R8", 32'(spiMiso), 32'h0);
    end
  end

  task automatic summary;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk({ctrlTest, ctrlSwReset, bankMode, threshGnd, threshSup, spiMiso} === '0, "R11",
        {ctrlTest, ctrlSwReset, bankMode, threshGnd[11:0], threshSup[11:0], spiMiso}, 32'h0);

    // R1, R2: control and bank-mode write and readback
    curReq = "R2";
    wr1(7'h02, 8'h01);
    rdChk(7'h02, 1, "R1");
    wr1(7'h04, 8'hFA);
    rdChk(7'h04, 1, "R2");

    // R3: 16-bit thresholds, high byte first
    curReq = "R3";
    wr2(7'h3A, 16'h1234);
    wr2(7'h3C, 16'hABCD);
    rdChk(7'h3A, 2, "R3");
    rdChk(7'h3C, 2, "R3");
    tx[0] = 8'h3A; tx[1] = 8'h77;
    xfer(2);
    rdChk(7'h3A, 2, "R3");

    // R4: full sense word, snapshot at command edge
    curReq = "R4";
    senseIn = 32'h0F0F_0F0F;
    senseAtCmd = 1; senseCmdVal = 32'hA5C3_9617;
    senseMid = 1; senseMidVal = 32'h1111_2222;
    rdChk(7'h78, 4, "R4");
    senseIn = 32'h8000_0001;
    rdChk(7'h78, 4, "R4");

    // R5: bank bytes
    curReq = "R5";
    senseIn = 32'hDEAD_BEEF;
    rdChk(7'h10, 1, "R5");
    rdChk(7'h12, 1, "R5");
    rdChk(7'h14, 1, "R5");
    rdChk(7'h16, 1, "R5");

    // R7: unmapped reads and ignored writes
    curReq = "R7";
    rdChk(7'h55, 2, "R7");
    rdChk(7'h11, 1, "R7");
    wr1(7'h78, 8'hFF);
    wr1(7'h11, 8'hFF);
    wr2(7'h3B, 16'hFFFF);
    rdChk(7'h3A, 2, "R7");

    // R10: beyond register width
    curReq = "R10";
    rdChk(7'h02, 3, "R10");
    rdChk(7'h3C, 4, "R10");
    tx[0] = 8'h04; tx[1] = 8'h05; tx[2] = 8'hFF; tx[3] = 8'hFF;
    xfer(4);
    rdChk(7'h04, 1, "R10");
    tx[0] = 8'h3C; tx[1] = 8'h55; tx[2] = 8'h66; tx[3] = 8'h99; tx[4] = 8'h88;
    xfer(5);
    rdChk(7'h3C, 2, "R10");

    // R9: aborted partial byte, then a clean write
    curReq = "R9";
    partialBits(5, 8'h84);
    wr1(7'h04, 8'h03);
    rdChk(7'h04, 1, "R9");
    partialBits(3, 8'hFF);
    rdChk(7'h3A, 2, "R9");

    // R6: software reset forces and blocks
    curReq = "R6";
    wr1(7'h02, 8'h02);
    wr1(7'h04, 8'h0F);
    wr2(7'h3C, 16'h4242);
    rdChk(7'h3C, 2, "R6");
    wr1(7'h02, 8'h00);
    rdChk(7'h04, 1, "R6");
    wr2(7'h3A, 16'h0206);
    rdChk(7'h3A, 2, "R6");

    repeat (10) @(negedge clk);
    summary();
  end

endmodule